// File: doc/BRIEF.md
# Multi-Mode Preset Timer

This block is a preset timer with three behaviours sharing one accumulator: on-delay, off-delay and retentive on-delay. A rung condition input starts, stops or holds timing depending on the selected mode. The accumulator advances by one count on each cycle in which the external time-base tick strobe is high. That strobe comes from a prescaler outside the block, with a 10 ms or 1 s period. A status word carries the enable, timing and done flags.

Control logic drives the rung condition, the preset and the mode select, and reads back the accumulator and the flags. Two further inputs act on the timer directly. A reset strobe returns the timer to its idle state. A write port forces the done flag, which pauses an on-delay or retentive timer without losing its count.

All state is registered. Inputs sampled at one rising clock edge are visible at the outputs immediately after that edge.

Top module: `ptmr_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the accumulator and the whole status word are cleared to zero.
- R2: The status word has enable at bit 15, timing at bit 14 and done at bit 13, and bits 12 to 0 read zero. The mode encodings are: 2'b00 on-delay, 2'b01 off-delay, 2'b10 retentive, and 2'b11 behaves exactly as on-delay.
- R3: In on-delay or retentive mode with the rung active and done clear, enable and timing are set, and the accumulator rises by one in each cycle whose tick is high. The cycle in which it reaches the limit clears timing and sets done. No tick means no advance.
- R4: In on-delay mode an inactive rung clears enable, timing and done, and zeroes the accumulator, in the next cycle.
- R5: Writing done = 1 through the write port while the rung is active freezes the accumulator from the following cycle on, and enable and timing stay set. Writing done = 0 resumes counting.
- R6: In off-delay mode an active rung sets enable and done, clears timing and zeroes the accumulator.
- R7: In off-delay mode with the rung inactive and done set, enable clears, timing is set, and the accumulator advances per tick. The cycle in which it reaches the limit clears both timing and done. A rung that returns active applies R6.
- R8: In retentive mode an inactive rung clears enable and timing, and keeps the accumulator and the done flag unchanged, whatever the tick does. Reactivating the rung continues counting from the held value.
- R9: The reset strobe clears the accumulator, enable, timing and done in on-delay and retentive modes. In off-delay mode it has no effect.
- R10: The limit is the preset clamped to 32,767. The accumulator never increments past the limit. A limit of zero sets done on the first active cycle in on-delay mode, and clears done on the first inactive cycle in off-delay mode.
- R11: A reset strobe in a non-off-delay mode wins over an active rung and over a done write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rung | input | 1 | Rung condition, active high |
| tick | input | 1 | Time-base tick strobe, one cycle per count |
| mode | input | 2 | Mode select (00 on-delay, 01 off-delay, 10 retentive, 11 on-delay) |
| preset | input | 16 | Preset value |
| res_strobe | input | 1 | Reset instruction strobe |
| done_wr | input | 1 | Done flag write enable |
| done_wdata | input | 1 | Value written to the done flag |
| acc | output | 16 | Accumulator |
| status | output | 16 | Status word: enable bit 15, timing bit 14, done bit 13 |

## Verification
The hardest states to reach are a paused timer that is resumed, and an off-delay timer in the middle of timing that receives a reset strobe. Each needs a specific history of rung, tick and done-write activity. Directed sequences build those histories step by step and check the exact accumulator and flag values at each cycle. A long directed run with an oversized preset drives the accumulator to the 32,767 clamp. Seeded random stimulus then mixes modes, small presets, forced done writes and reset strobes against a bench reference model.

// File: rtl/ptmr_pkg.sv
// Package ptmr_pkg: shared mode encoding and flag type for the preset timer.
// Assumes a 2-bit mode select; the fourth code is treated as on-delay.
package ptmr_pkg;
    typedef enum logic [1:0] {
        MODE_ON     = 2'b00,
        MODE_OFF    = 2'b01,
        MODE_RET    = 2'b10,
        MODE_ON_ALT = 2'b11
    } ptmr_mode_e;

    typedef struct packed {
        logic en;
        logic tt;
        logic dn;
    } ptmr_flags_t;
endpackage

// File: rtl/ptmr_limit.sv
// Module ptmr_limit: clamps the preset to the largest positive value that
// the accumulator may hold (2**(W-1)-1).
// Assumes W >= 2. Purely combinational.
module ptmr_limit #(
    parameter int W = 16
) (
    input  logic [W-1:0] preset,
    output logic [W-1:0] lim
);
    localparam logic [W-1:0] ACC_MAX = {1'b0, {(W-1){1'b1}}};

    // choose preset or the clamp ceiling
    always_comb begin
        lim = (preset > ACC_MAX) ? ACC_MAX : preset;
    end
endmodule

// File: rtl/ptmr_next.sv
// Module ptmr_next: next-state function of the timer for all three modes.
// Assumes lim is already clamped. The reset strobe is applied last so
// that it dominates the rung and the done write (ignored in off-delay).
module ptmr_next
    import ptmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [1:0]   mode,
    input  logic         rung,
    input  logic         tick,
    input  logic         res_strobe,
    input  logic         done_wr,
    input  logic         done_wdata,
    input  logic [W-1:0] lim,
    input  logic [W-1:0] acc,
    input  ptmr_flags_t  flags,
    output logic [W-1:0] acc_n,
    output ptmr_flags_t  flags_n
);
    ptmr_mode_e   mode_e;
    logic         can_step;
    logic [W-1:0] acc_step;
    logic         at_lim;

    // decode mode and form the candidate incremented accumulator
    always_comb begin
        mode_e   = ptmr_mode_e'(mode);
        can_step = tick && (acc < lim);
        acc_step = can_step ? acc + W'(1) : acc;
        at_lim   = (acc_step >= lim);
    end

    // per-mode flag and accumulator update, then done write, then reset
    always_comb begin
        acc_n   = acc;
        flags_n = flags;
        if (mode_e == MODE_OFF) begin
            if (rung) begin
                flags_n = '{en: 1'b1, tt: 1'b0, dn: 1'b1};
                acc_n   = '0;
            end else begin
                flags_n.en = 1'b0;
                if (flags.dn) begin
                    acc_n      = acc_step;
                    flags_n.tt = !at_lim;
                    flags_n.dn = !at_lim;
                end else begin
                    flags_n.tt = 1'b0;
                end
            end
        end else begin
            if (rung) begin
                flags_n.en = 1'b1;
                if (!flags.dn) begin
                    acc_n      = acc_step;
                    flags_n.tt = !at_lim;
                    flags_n.dn = at_lim;
                end
            end else begin
                flags_n.en = 1'b0;
                flags_n.tt = 1'b0;
                if (mode_e != MODE_RET) begin
                    flags_n.dn = 1'b0;
                    acc_n      = '0;
                end
            end
        end
        if (done_wr) begin
            flags_n.dn = done_wdata;
        end
        if (res_strobe && (mode_e != MODE_OFF)) begin
            flags_n = '{en: 1'b0, tt: 1'b0, dn: 1'b0};
            acc_n   = '0;
        end
    end
endmodule

// File: rtl/ptmr_state.sv
// Module ptmr_state: holds the accumulator and the three flags.
// Assumes a synchronous active-low reset.
module ptmr_state
    import ptmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] acc_n,
    input  ptmr_flags_t  flags_n,
    output logic [W-1:0] acc,
    output ptmr_flags_t  flags
);
    // register next state, clearing on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            flags <= '{en: 1'b0, tt: 1'b0, dn: 1'b0};
        end else begin
            acc   <= acc_n;
            flags <= flags_n;
        end
    end
endmodule

// File: rtl/ptmr_unit.sv
// Module ptmr_unit: multi-mode preset timer (on-delay, off-delay,
// retentive) with a W-bit accumulator and a status word.
// Assumes tick is a one-cycle strobe from an external prescaler and W >= 4.
module ptmr_unit
    import ptmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rung,
    input  logic         tick,
    input  logic [1:0]   mode,
    input  logic [W-1:0] preset,
    input  logic         res_strobe,
    input  logic         done_wr,
    input  logic         done_wdata,
    output logic [W-1:0] acc,
    output logic [W-1:0] status
);
    localparam int EN_BIT = W - 1;
    localparam int TT_BIT = W - 2;
    localparam int DN_BIT = W - 3;

    logic [W-1:0] lim;
    logic [W-1:0] acc_n;
    ptmr_flags_t  flags;
    ptmr_flags_t  flags_n;

    ptmr_limit #(.W(W)) u_limit (
        .preset (preset),
        .lim    (lim)
    );

    ptmr_next #(.W(W)) u_next (
        .mode       (mode),
        .rung       (rung),
        .tick       (tick),
        .res_strobe (res_strobe),
        .done_wr    (done_wr),
        .done_wdata (done_wdata),
        .lim        (lim),
        .acc        (acc),
        .flags      (flags),
        .acc_n      (acc_n),
        .flags_n    (flags_n)
    );

    ptmr_state #(.W(W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_n   (acc_n),
        .flags_n (flags_n),
        .acc     (acc),
        .flags   (flags)
    );

    // assemble the status word from the flags
    always_comb begin
        status         = '0;
        status[EN_BIT] = flags.en;
        status[TT_BIT] = flags.tt;
        status[DN_BIT] = flags.dn;
    end
endmodule

// File: rtl/ptmr_checker.sv
// Module ptmr_checker: temporal properties of ptmr_unit, bound to it below.
// Assumes the same W as the unit it watches.
module ptmr_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rung,
    input logic         tick,
    input logic [1:0]   mode,
    input logic [W-1:0] preset,
    input logic         res_strobe,
    input logic         done_wr,
    input logic         done_wdata,
    input logic [W-1:0] acc,
    input logic [W-1:0] status
);
    localparam logic [W-1:0] CEIL = {1'b0, {(W-1){1'b1}}};
    localparam int DN = W - 3;

    logic [W-1:0] c_lim;
    logic         is_off;
    logic         is_ret;
    logic         hard_res;

    // independent view of clamp and mode classes
    always_comb begin
        c_lim    = (preset > CEIL) ? CEIL : preset;
        is_off   = (mode == 2'b01);
        is_ret   = (mode == 2'b10);
        hard_res = res_strobe && !is_off;
    end

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status[W-4:0] == '0);

    p_acc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != $past(acc)) |->
        ((acc == '0) || ((acc == $past(acc) + W'(1)) && ($past(acc) < $past(c_lim)))));

    p_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ((acc == $past(acc)) || (acc == '0)));

    p_ondelay_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_off && !is_ret && !rung && !res_strobe && !done_wr) |=>
        ((acc == '0) && (status == '0)));

    p_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_off && rung && status[DN] && !res_strobe && !done_wr) |=> $stable(acc));

    p_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_wr && !hard_res) |=> (status[DN] == $past(done_wdata)));

    p_ret_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ret && !rung && !res_strobe && !done_wr) |=>
        ($stable(acc) && $stable(status[DN])));

    p_res_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hard_res |=> ((acc == '0) && (status == '0)));

    p_off_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_off && rung && !done_wr) |=> ((acc == '0) && (status[W-1:W-3] == 3'b101)));
endmodule

bind ptmr_unit ptmr_checker #(.W(W)) u_ptmr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rung       (rung),
    .tick       (tick),
    .mode       (mode),
    .preset     (preset),
    .res_strobe (res_strobe),
    .done_wr    (done_wr),
    .done_wdata (done_wdata),
    .acc        (acc),
    .status     (status)
);

// File: tb/test_ptmr_unit.sv
module test_ptmr_unit;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rung = 1'b0;
    logic         tick = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] preset = '0;
    logic         res_strobe = 1'b0;
    logic         done_wr = 1'b0;
    logic         done_wdata = 1'b0;
    logic [W-1:0] acc;
    logic [W-1:0] status;

    int n_chk = 0;
    int n_fail = 0;
    int n_cyc = 0;

    logic [W-1:0] m_acc = '0;
    logic m_en = 1'b0, m_tt = 1'b0, m_dn = 1'b0;

    ptmr_unit #(.W(W)) i_ptmr_unit (
        .clk(clk), .rst_n(rst_n), .rung(rung), .tick(tick), .mode(mode),
        .preset(preset), .res_strobe(res_strobe), .done_wr(done_wr),
        .done_wdata(done_wdata), .acc(acc), .status(status)
    );

    always #4 clk = ~clk;

    always @(posedge clk) n_cyc <= n_cyc + 1;

    function automatic logic [W-1:0] exp_status();
        return {m_en, m_tt, m_dn, 13'b0};
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model from the requirements: one cycle of the timer
    task automatic model();
        logic [W-1:0] lim, nxt;
        logic en, tt, dn, hit;
        lim = (preset > 16'h7FFF) ? 16'h7FFF : preset;
        nxt = (tick && m_acc < lim) ? m_acc + 16'd1 : m_acc;
        hit = (nxt >= lim);
        en = m_en; tt = m_tt; dn = m_dn;
        if (!rst_n) begin
            m_acc = '0; m_en = 0; m_tt = 0; m_dn = 0;
            return;
        end
        if (mode == 2'b01) begin
            if (rung) begin en = 1; tt = 0; dn = 1; m_acc = '0; end
            else begin
                en = 0;
                if (m_dn) begin m_acc = nxt; tt = !hit; dn = !hit; end
                else tt = 0;
            end
        end else if (rung) begin
            en = 1;
            if (!m_dn) begin m_acc = nxt; tt = !hit; dn = hit; end
        end else begin
            en = 0; tt = 0;
            if (mode != 2'b10) begin dn = 0; m_acc = '0; end
        end
        if (done_wr) dn = done_wdata;
        if (res_strobe && mode != 2'b01) begin
            en = 0; tt = 0; dn = 0; m_acc = '0;
        end
        m_en = en; m_tt = tt; m_dn = dn;
    endtask

    // one cycle: model, clock edge, compare at the following falling edge
    task automatic step(input string tag, input bit do_chk = 1);
        model();
        @(posedge clk);
        @(negedge clk);
        if (do_chk) begin
            chk({tag, " acc"}, acc, m_acc);
            chk({tag, " status"}, status, exp_status());
        end
    endtask

    task automatic setin(input logic r, input logic t, input logic rs, input logic dw, input logic dd);
        rung = r; tick = t; res_strobe = rs; done_wr = dw; done_wdata = dd;
    endtask

    initial begin : watchdog
        wait (n_cyc > 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000", n_cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        @(negedge clk);
        step("R1", 1'b0);
        step("R1", 1'b0);
        step("R1");
        chk("R1 reset acc", acc, 16'h0000);
        chk("R1 reset status", status, 16'h0000);
        rst_n = 1'b1;

        // on-delay counting to preset 3
        mode = 2'b00; preset = 16'd3; setin(1, 1, 0, 0, 0);
        step("R3"); chk("R3 first count", acc, 16'd1); chk("R3 timing", status, 16'hC000);
        step("R3");
        step("R3"); chk("R3 done acc", acc, 16'd3); chk("R3 done", status, 16'hA000);
        step("R10"); chk("R10 no pass", acc, 16'd3);
        setin(0, 1, 0, 0, 0);
        step("R4"); chk("R4 cleared", {acc | status}, 16'h0000);

        // pause by forced done and resume
        preset = 16'd5; setin(1, 1, 0, 0, 0);
        step("R5");
        setin(1, 1, 0, 1, 1);
        step("R5"); chk("R5 forced", status, 16'hE000);
        setin(1, 1, 0, 0, 0);
        step("R5"); chk("R5 frozen acc", acc, 16'd2); chk("R5 frozen status", status, 16'hE000);
        step("R5"); chk("R5 still frozen", acc, 16'd2);
        setin(1, 1, 0, 1, 0);
        step("R5"); chk("R5 unforce", status, 16'hC000);
        setin(1, 1, 0, 0, 0);
        step("R5"); chk("R5 resumed", acc, 16'd3);
        setin(0, 0, 0, 0, 0);
        step("R4");

        // off-delay
        mode = 2'b01; preset = 16'd2; setin(1, 1, 0, 0, 0);
        step("R6"); chk("R6 active", status, 16'hA000); chk("R6 acc", acc, 16'd0);
        setin(0, 1, 0, 0, 0);
        step("R7"); chk("R7 timing", status, 16'h6000); chk("R7 acc", acc, 16'd1);
        step("R7"); chk("R7 expired", status, 16'h0000); chk("R7 acc end", acc, 16'd2);
        step("R7");
        setin(1, 0, 0, 0, 0);
        step("R7"); chk("R7 return", status, 16'hA000);
        setin(0, 0, 0, 0, 0);
        step("R7"); chk("R7 timing again", status, 16'h6000);
        setin(0, 0, 1, 0, 0);
        step("R9"); chk("R9 off ignored", status, 16'h6000); chk("R9 off acc", acc, 16'd0);
        setin(0, 1, 1, 0, 0);
        step("R9"); chk("R9 off ignored count", acc, 16'd1);
        setin(1, 0, 0, 0, 0);
        step("R6");

        // retentive
        mode = 2'b10; preset = 16'd4; setin(0, 0, 1, 0, 0);
        step("R9"); chk("R9 ret clear", {acc | status}, 16'h0000);
        setin(1, 1, 0, 0, 0);
        step("R8"); step("R8");
        setin(0, 1, 0, 0, 0);
        step("R8"); chk("R8 hold acc", acc, 16'd2); chk("R8 flags", status, 16'h0000);
        step("R8"); chk("R8 hold with tick", acc, 16'd2);
        setin(1, 1, 0, 0, 0);
        step("R8"); chk("R8 continue", acc, 16'd3);
        step("R8"); chk("R8 done", status, 16'hA000);
        setin(0, 1, 0, 0, 0);
        step("R8"); chk("R8 done kept", status, 16'h2000); chk("R8 acc kept", acc, 16'd4);
        setin(0, 0, 1, 0, 0);
        step("R9"); chk("R9 ret reset", {acc | status}, 16'h0000);

        // zero preset
        mode = 2'b00; preset = 16'd0; setin(1, 1, 0, 0, 0);
        step("R10"); chk("R10 zero on-delay", status, 16'hA000);
        mode = 2'b01; setin(1, 0, 0, 0, 0);
        step("R10");
        setin(0, 0, 0, 0, 0);
        step("R10"); chk("R10 zero off-delay", status, 16'h0000);

        // reset strobe priority
        mode = 2'b00; preset = 16'd5; setin(1, 1, 1, 1, 1);
        step("R11"); chk("R11 reset wins", {acc | status}, 16'h0000);

        // alternate on-delay code
        mode = 2'b11; preset = 16'd2; setin(1, 1, 0, 0, 0);
        step("R2"); chk("R2 mode3 acc", acc, 16'd1); chk("R2 mode3 status", status, 16'hC000);
        setin(0, 0, 0, 0, 0);
        step("R2"); chk("R2 mode3 drop", status, 16'h0000);

        // clamp: oversized preset stops at 32767
        mode = 2'b00; preset = 16'hFFFF; setin(1, 1, 0, 0, 0);
        for (int i = 0; i < 32766; i++) step("R10", 1'b0);
        step("R10"); chk("R10 clamp acc", acc, 16'h7FFF); chk("R10 clamp done", status, 16'hA000);
        step("R10"); chk("R10 clamp hold", acc, 16'h7FFF);
        setin(0, 0, 0, 0, 0);
        step("R4");

        // seeded random mix
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 40) == 0) mode = 2'($urandom);
            if (($urandom % 30) == 0)
                preset = (($urandom % 8) == 0) ? 16'($urandom) : 16'($urandom % 12);
            if (($urandom % 6) == 0) rung = !rung;
            tick = 1'($urandom);
            res_strobe = (($urandom % 30) == 0);
            done_wr = (($urandom % 25) == 0);
            done_wdata = 1'($urandom);
            step("R3 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule